// File: doc/BRIEF.md
# Byte-Step I2C Master Controller

This block is the sequencing core of a processor-driven I2C master. Software works it through three registers: a control register (enable, start, stop, acknowledge-enable and an interrupt flag), a data register and a status register. A transfer opens with a start request. Software then loads an address byte into the data register and moves data bytes one at a time. Every completed step posts a fixed 8-bit status code and raises the interrupt flag. Software reads the code to decide what to do next.

The bus side works at the transaction level. The controller emits address, write, read and stop messages. A responder answers with acknowledge bits and read data. Step delays are counted in bit periods, and one bit period is one pulse on `tick_i`. A start step takes 3 bit periods and a byte step takes 9. The status code is posted on the clock edge that samples the last tick of its delay.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset the status output reads 0xF8, the data register reads 0xFF, all control bits read 0 and no bus message is emitted.
- R2: Control bits are enable (bit 0), start (bit 1), stop (bit 2), acknowledge-enable (bit 3) and interrupt flag (bit 4). When start changes from 0 to 1, status 0x08 is posted on the 3rd tick after the write. If a transaction is already open, 0x10 is posted instead. Posting sets the interrupt flag.
- R3: The first byte step after a start sends the data register as the address in a message of kind 1 and stores it as the peer address. Bit 0 of the address selects read (1) or write (0). On the 9th tick the block posts 0x18 or 0x20 for a write address, or 0x40 or 0x48 for a read address. The ACK code is chosen only if the responder acknowledged during the delay; no response counts as NACK.
- R4: A write byte step runs only if the data register has been written since the previous byte step. It sends a message of kind 3 carrying the data byte and posts 0x28 on ACK or 0x30 on NACK 9 ticks later. Without that data-register write, no message is sent and nothing is posted.
- R5: A read byte step runs when the read-ready latch is set. Sending a read address sets this latch, and so does a data-register read. The step sends a message of kind 4 whose ack bit equals the acknowledge-enable bit. It posts 0x50 if that bit is 1 and 0x58 if it is 0. Read data from the responder loads the data register.
- R6: A byte step runs only when a control write has its interrupt-flag bit at 1 while an interrupt is pending, and the written start and stop bits are both 0. A control write with that bit at 0 starts no step and leaves the flag set.
- R7: When stop changes from 0 to 1, the block emits a message of kind 2 if a transaction is open and nothing otherwise. In both cases it returns to idle, so the next start posts 0x08.
- R8: When enable changes from 1 to 0, the block clears start, stop, acknowledge-enable and the interrupt flag. It loads 0xFF into the data register, sets the status code field to 0xF8 without raising an interrupt, and cancels any pending step.
- R9: The status register reads the code in bits 7..3 and the prescaler in bits 1..0. A status write changes only the prescaler.
- R10: While enable is 0, the block ignores control writes that leave enable at 0 and ignores responder inputs.
- R11: Only one delayed status update can be pending at a time. A new start request replaces a pending one, so only the later code is posted.
- R12: Writing the interrupt-flag bit as 1 clears a pending interrupt on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One pulse per bit period |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 5 | Control write value |
| data_wr_i | input | 1 | Data register write strobe |
| data_wdata_i | input | 8 | Data write value |
| data_rd_i | input | 1 | Data register read strobe |
| stat_wr_i | input | 1 | Status register write strobe |
| stat_wdata_i | input | 2 | Prescaler write value |
| rsp_ack_vld_i | input | 1 | Responder acknowledge valid |
| rsp_ack_i | input | 1 | Responder acknowledge (1 = ACK) |
| rsp_data_vld_i | input | 1 | Responder read data valid |
| rsp_data_i | input | 8 | Responder read data |
| ctrl_o | output | 5 | Control register contents |
| data_o | output | 8 | Data register contents |
| status_o | output | 8 | Status register contents |
| irq_o | output | 1 | Interrupt flag |
| msg_vld_o | output | 1 | Bus message valid, one cycle |
| msg_kind_o | output | 3 | 1 address, 2 stop, 3 write, 4 read |
| msg_addr_o | output | 8 | Address or peer address |
| msg_data_o | output | 8 | Data byte of a write message |
| msg_ack_o | output | 1 | Acknowledge to return on a read |

## Verification
The hardest situation to reach from the ports is a start request that replaces another one which is still pending. The bench writes start, then drops it and raises it again within a few clocks, all inside the 3-tick window. It then counts interrupt rising edges to show that only the repeated-start code was posted. Gated byte steps are also hard to reach, because they need a pending interrupt together with a missing data-register write. The bench reaches this by clearing the flag with no prior write and observing that neither a message nor a new interrupt follows.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int CB_EN    = 0;
  localparam int CB_START = 1;
  localparam int CB_STOP  = 2;
  localparam int CB_ACKEN = 3;
  localparam int CB_IRQ   = 4;
  localparam int CTRL_W   = 5;

  localparam int LEN_START = 3;
  localparam int LEN_BYTE  = 9;

  localparam logic [7:0] ST_IDLE = 8'hF8;

  typedef enum logic [2:0] {
    PK_START, PK_RSTART, PK_ADDR_W, PK_ADDR_R, PK_DATA_W, PK_DATA_R_ACK, PK_DATA_R_NACK
  } post_kind_e;

  typedef enum logic [2:0] {
    MSG_NONE = 3'd0, MSG_ADDR = 3'd1, MSG_STOP = 3'd2, MSG_WRITE = 3'd3, MSG_READ = 3'd4
  } msg_kind_e;

  function automatic logic [7:0] post_code(input post_kind_e k, input logic ack);
    case (k)
      PK_START:       post_code = 8'h08;
      PK_RSTART:      post_code = 8'h10;
      PK_ADDR_W:      post_code = ack ? 8'h18 : 8'h20;
      PK_ADDR_R:      post_code = ack ? 8'h40 : 8'h48;
      PK_DATA_W:      post_code = ack ? 8'h28 : 8'h30;
      PK_DATA_R_ACK:  post_code = 8'h50;
      PK_DATA_R_NACK: post_code = 8'h58;
      default:        post_code = ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/i2cm_step_timer.sv
module i2cm_step_timer
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_len_i,
  input  post_kind_e       load_kind_i,
  input  logic             cancel_i,
  output logic             fire_o,
  output post_kind_e       fire_kind_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  post_kind_e       kind_q, kind_d;

  assign fire_o      = busy_q && tick_i && (cnt_q == CNT_W'(1)) && !load_i && !cancel_i;
  assign fire_kind_o = kind_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    if (cancel_i) begin
      busy_d = 1'b0;
    end else if (load_i) begin
      busy_d = 1'b1;
      cnt_d  = load_len_i;
      kind_d = load_kind_i;
    end else if (fire_o) begin
      busy_d = 1'b0;
    end else if (busy_q && tick_i) begin
      cnt_d = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= PK_START;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
    end
  end

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick_i && !load_i && !cancel_i) |=> $stable(cnt_q));
  // R11
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (busy_q && cnt_q == $past(load_len_i)));
endmodule

// File: rtl/i2cm_seq.sv
module i2cm_seq
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              data_wr_i,
  input  logic [7:0]        data_wdata_i,
  input  logic              data_rd_i,
  input  logic              stat_wr_i,
  input  logic [1:0]        stat_wdata_i,
  input  logic              rsp_ack_vld_i,
  input  logic              rsp_ack_i,
  input  logic              rsp_data_vld_i,
  input  logic [7:0]        rsp_data_i,
  input  logic              fire_i,
  input  post_kind_e        fire_kind_i,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_len_o,
  output post_kind_e        load_kind_o,
  output logic              cancel_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [7:0]        data_o,
  output logic [7:0]        status_o,
  output logic              irq_o,
  output logic              msg_vld_o,
  output logic [2:0]        msg_kind_o,
  output logic [7:0]        msg_addr_o,
  output logic [7:0]        msg_data_o,
  output logic              msg_ack_o
);
  logic       en_q, en_d, sta_q, sta_d, sto_q, sto_d, acken_q, acken_d, irq_q, irq_d;
  logic [7:0] data_q, data_d, peer_q, peer_d;
  logic [4:0] code_q, code_d;
  logic [1:0] presc_q, presc_d;
  logic       open_q, open_d, adone_q, adone_d, wrdy_q, wrdy_d, rrdy_q, rrdy_d, ack_q, ack_d;
  logic       mvld_q, mvld_d, mack_q, mack_d;
  msg_kind_e  mkind_q, mkind_d;
  logic [7:0] maddr_q, maddr_d, mdata_q, mdata_d, posted;
  logic       cleared;

  assign ctrl_o     = {irq_q, acken_q, sto_q, sta_q, en_q};
  assign data_o     = data_q;
  assign status_o   = {code_q, 1'b0, presc_q};
  assign irq_o      = irq_q;
  assign msg_vld_o  = mvld_q;
  assign msg_kind_o = mkind_q;
  assign msg_addr_o = maddr_q;
  assign msg_data_o = mdata_q;
  assign msg_ack_o  = mack_q;
  assign posted     = post_code(fire_kind_i, ack_q);
  assign cleared    = irq_q && ctrl_wdata_i[CB_IRQ];

  always_comb begin
    en_d = en_q; sta_d = sta_q; sto_d = sto_q; acken_d = acken_q; irq_d = irq_q;
    data_d = data_q; peer_d = peer_q; code_d = code_q; presc_d = presc_q;
    open_d = open_q; adone_d = adone_q; wrdy_d = wrdy_q; rrdy_d = rrdy_q; ack_d = ack_q;
    mvld_d = 1'b0; mkind_d = MSG_NONE; maddr_d = maddr_q; mdata_d = mdata_q; mack_d = 1'b0;
    load_o = 1'b0; load_len_o = CNT_W'(LEN_START); load_kind_o = PK_START; cancel_o = 1'b0;

    if (en_q && rsp_ack_vld_i)  ack_d  = rsp_ack_i;
    if (en_q && rsp_data_vld_i) data_d = rsp_data_i;
    if (data_wr_i) begin
      data_d = data_wdata_i;
      wrdy_d = 1'b1;
    end
    if (en_q && data_rd_i) rrdy_d  = 1'b1;
    if (stat_wr_i)         presc_d = stat_wdata_i;
    if (fire_i) begin
      code_d = posted[7:3];
      irq_d  = 1'b1;
    end

    if (ctrl_wr_i) begin
      if (en_q && !ctrl_wdata_i[CB_EN]) begin
        en_d = 1'b0; sta_d = 1'b0; sto_d = 1'b0; acken_d = 1'b0; irq_d = 1'b0;
        data_d = 8'hFF; code_d = ST_IDLE[7:3]; peer_d = '0;
        open_d = 1'b0; adone_d = 1'b0; wrdy_d = 1'b0; rrdy_d = 1'b0; ack_d = 1'b0;
        cancel_o = 1'b1;
      end else if (ctrl_wdata_i[CB_EN]) begin
        en_d    = 1'b1;
        sta_d   = ctrl_wdata_i[CB_START];
        sto_d   = ctrl_wdata_i[CB_STOP];
        acken_d = ctrl_wdata_i[CB_ACKEN];
        if (cleared) irq_d = 1'b0;
        if (!sto_q && ctrl_wdata_i[CB_STOP]) begin
          if (open_q) begin
            mvld_d = 1'b1; mkind_d = MSG_STOP; maddr_d = peer_q;
          end
          open_d = 1'b0; adone_d = 1'b0;
        end
        if (!sta_q && ctrl_wdata_i[CB_START]) begin
          load_o      = 1'b1;
          load_len_o  = CNT_W'(LEN_START);
          load_kind_o = open_d ? PK_RSTART : PK_START;
          peer_d = '0; open_d = 1'b1; adone_d = 1'b0;
        end
        if (cleared && !ctrl_wdata_i[CB_START] && !ctrl_wdata_i[CB_STOP]) begin
          ack_d      = 1'b0;
          load_len_o = CNT_W'(LEN_BYTE);
          if (adone_d) begin
            if (peer_q[0] && rrdy_q) begin
              load_o = 1'b1;
              load_kind_o = ctrl_wdata_i[CB_ACKEN] ? PK_DATA_R_ACK : PK_DATA_R_NACK;
              mvld_d = 1'b1; mkind_d = MSG_READ; maddr_d = peer_q;
              mack_d = ctrl_wdata_i[CB_ACKEN];
            end else if (!peer_q[0] && wrdy_q) begin
              load_o = 1'b1; load_kind_o = PK_DATA_W;
              mvld_d = 1'b1; mkind_d = MSG_WRITE; maddr_d = peer_q; mdata_d = data_q;
            end
          end else begin
            adone_d = 1'b1; peer_d = data_q;
            load_o = 1'b1; load_kind_o = data_q[0] ? PK_ADDR_R : PK_ADDR_W;
            if (data_q[0]) rrdy_d = 1'b1;
            mvld_d = 1'b1; mkind_d = MSG_ADDR; maddr_d = data_q;
          end
          wrdy_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; sta_q <= 1'b0; sto_q <= 1'b0; acken_q <= 1'b0; irq_q <= 1'b0;
      data_q <= 8'hFF; peer_q <= '0; code_q <= ST_IDLE[7:3]; presc_q <= '0;
      open_q <= 1'b0; adone_q <= 1'b0; wrdy_q <= 1'b0; rrdy_q <= 1'b0; ack_q <= 1'b0;
      mvld_q <= 1'b0; mkind_q <= MSG_NONE; maddr_q <= '0; mdata_q <= '0; mack_q <= 1'b0;
    end else begin
      en_q <= en_d; sta_q <= sta_d; sto_q <= sto_d; acken_q <= acken_d; irq_q <= irq_d;
      data_q <= data_d; peer_q <= peer_d; code_q <= code_d; presc_q <= presc_d;
      open_q <= open_d; adone_q <= adone_d; wrdy_q <= wrdy_d; rrdy_q <= rrdy_d; ack_q <= ack_d;
      mvld_q <= mvld_d; mkind_q <= mkind_d; maddr_q <= maddr_d; mdata_q <= mdata_d;
      mack_q <= mack_d;
    end
  end

  // R2
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(fire_i));
  // R8
  disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr_i && en_q && !ctrl_wdata_i[CB_EN]) |=>
      (code_q == ST_IDLE[7:3] && !irq_q && data_q == 8'hFF && !en_q));
  // R9
  stat_code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr_i && !ctrl_wr_i && !fire_i) |=> $stable(code_q));
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !ctrl_wr_i) |=> (!mvld_q && !irq_q && $stable(code_q)));
  // R7
  stop_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mvld_q && mkind_q == MSG_STOP) |-> $past(open_q));
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2cm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        ctrl_wr_i,
  input  logic [4:0]  ctrl_wdata_i,
  input  logic        data_wr_i,
  input  logic [7:0]  data_wdata_i,
  input  logic        data_rd_i,
  input  logic        stat_wr_i,
  input  logic [1:0]  stat_wdata_i,
  input  logic        rsp_ack_vld_i,
  input  logic        rsp_ack_i,
  input  logic        rsp_data_vld_i,
  input  logic [7:0]  rsp_data_i,
  output logic [4:0]  ctrl_o,
  output logic [7:0]  data_o,
  output logic [7:0]  status_o,
  output logic        irq_o,
  output logic        msg_vld_o,
  output logic [2:0]  msg_kind_o,
  output logic [7:0]  msg_addr_o,
  output logic [7:0]  msg_data_o,
  output logic        msg_ack_o
);
  logic             load, cancel, fire;
  logic [CNT_W-1:0] load_len;
  post_kind_e       load_kind, fire_kind;

  i2cm_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .load_i(load), .load_len_i(load_len), .load_kind_i(load_kind), .cancel_i(cancel),
    .fire_o(fire), .fire_kind_o(fire_kind)
  );

  i2cm_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .data_wr_i(data_wr_i), .data_wdata_i(data_wdata_i), .data_rd_i(data_rd_i),
    .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
    .rsp_ack_vld_i(rsp_ack_vld_i), .rsp_ack_i(rsp_ack_i),
    .rsp_data_vld_i(rsp_data_vld_i), .rsp_data_i(rsp_data_i),
    .fire_i(fire), .fire_kind_i(fire_kind),
    .load_o(load), .load_len_o(load_len), .load_kind_o(load_kind), .cancel_o(cancel),
    .ctrl_o(ctrl_o), .data_o(data_o), .status_o(status_o), .irq_o(irq_o),
    .msg_vld_o(msg_vld_o), .msg_kind_o(msg_kind_o), .msg_addr_o(msg_addr_o),
    .msg_data_o(msg_data_o), .msg_ack_o(msg_ack_o)
  );
endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;
  localparam logic [4:0] EN = 5'h01, ST = 5'h02, SP = 5'h04, AK = 5'h08, IQ = 5'h10;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic ctrl_wr = 0, data_wr = 0, data_rd = 0, stat_wr = 0;
  logic [4:0] ctrl_wdata = '0;
  logic [7:0] data_wdata = '0, rsp_data = '0;
  logic [1:0] stat_wdata = '0;
  logic rsp_ack_vld = 0, rsp_ack = 0, rsp_data_vld = 0;
  logic [4:0] ctrl_o;
  logic [7:0] data_o, status_o, msg_addr_o, msg_data_o;
  logic [2:0] msg_kind_o;
  logic irq_o, msg_vld_o, msg_ack_o;

  int n_chk = 0, n_fail = 0, rises = 0, tdiv = 0;
  string cur_req = "R1";
  bit done = 0, prev_irq = 0;
  int mq_kind[$], mq_addr[$], mq_data[$], mq_ack[$];

  // reference model state
  int m_en, m_sta, m_sto, m_ak, m_irq, m_data, m_peer, m_code, m_pre;
  int m_open, m_adone, m_wr, m_rd, m_ack, p_act, p_cnt, p_kind;

  always #10 clk = ~clk;

  i2c_byte_master u_i2c_byte_master (
    .clk(clk), .rst_n(rst_n), .tick_i(tick),
    .ctrl_wr_i(ctrl_wr), .ctrl_wdata_i(ctrl_wdata),
    .data_wr_i(data_wr), .data_wdata_i(data_wdata), .data_rd_i(data_rd),
    .stat_wr_i(stat_wr), .stat_wdata_i(stat_wdata),
    .rsp_ack_vld_i(rsp_ack_vld), .rsp_ack_i(rsp_ack),
    .rsp_data_vld_i(rsp_data_vld), .rsp_data_i(rsp_data),
    .ctrl_o(ctrl_o), .data_o(data_o), .status_o(status_o), .irq_o(irq_o),
    .msg_vld_o(msg_vld_o), .msg_kind_o(msg_kind_o), .msg_addr_o(msg_addr_o),
    .msg_data_o(msg_data_o), .msg_ack_o(msg_ack_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int code_of(input int k, input int ack);
    case (k)
      0: return 8'h08;
      1: return 8'h10;
      2: return ack != 0 ? 8'h18 : 8'h20;
      3: return ack != 0 ? 8'h40 : 8'h48;
      4: return ack != 0 ? 8'h28 : 8'h30;
      5: return 8'h50;
      default: return 8'h58;
    endcase
  endfunction

  // bit-period ticks: one every 4 clocks
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    tick = (tdiv == 0);
  end

  // behavioural reference model, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_sta = 0; m_sto = 0; m_ak = 0; m_irq = 0; m_data = 8'hFF; m_peer = 0;
      m_code = 8'hF8; m_pre = 0; m_open = 0; m_adone = 0; m_wr = 0; m_rd = 0; m_ack = 0;
      p_act = 0; p_cnt = 0; p_kind = 0;
    end else begin
      automatic int n_ack = m_ack, n_data = m_data, n_wr = m_wr, n_rd = m_rd;
      automatic int n_code = m_code, n_irq = m_irq, ld = 0, ld_len = 0, ld_kind = 0;
      automatic bit cancel = 0;
      automatic bit fire = p_act != 0 && tick && p_cnt == 1;
      if (m_en != 0 && rsp_ack_vld) n_ack = rsp_ack;
      if (m_en != 0 && rsp_data_vld) n_data = rsp_data;
      if (data_wr) begin n_data = data_wdata; n_wr = 1; end
      if (data_rd && m_en != 0) n_rd = 1;
      if (stat_wr) m_pre = stat_wdata;
      if (ctrl_wr && m_en != 0 && !ctrl_wdata[0]) begin
        cancel = 1; fire = 0;
      end else if (ctrl_wr && ctrl_wdata[0] && m_sta == 0 && ctrl_wdata[1]) begin
        fire = 0;
      end else if (ctrl_wr && ctrl_wdata[0] && m_irq != 0 && ctrl_wdata[4] &&
                   !ctrl_wdata[1] && !ctrl_wdata[2]) begin
        if (m_adone == 0 || (m_peer[0] && m_rd != 0) || (!m_peer[0] && m_wr != 0)) fire = 0;
      end
      if (fire) begin n_code = code_of(p_kind, m_ack); n_irq = 1; end
      if (ctrl_wr) begin
        if (m_en != 0 && !ctrl_wdata[0]) begin
          m_en = 0; m_sta = 0; m_sto = 0; m_ak = 0; n_irq = 0; n_data = 8'hFF;
          n_code = 8'hF8; m_peer = 0; m_open = 0; m_adone = 0; n_wr = 0; n_rd = 0; n_ack = 0;
        end else if (ctrl_wdata[0]) begin
          automatic bit clr = m_irq != 0 && ctrl_wdata[4];
          if (clr) n_irq = 0;
          if (m_sto == 0 && ctrl_wdata[2]) begin
            if (m_open != 0) begin
              mq_kind.push_back(-1);
            end
            m_open = 0; m_adone = 0;
          end
          if (m_sta == 0 && ctrl_wdata[1]) begin
            ld = 1; ld_len = 3; ld_kind = (m_open != 0) ? 1 : 0;
            m_peer = 0; m_open = 1; m_adone = 0;
          end
          if (clr && !ctrl_wdata[1] && !ctrl_wdata[2]) begin
            n_ack = 0;
            if (m_adone != 0) begin
              if (m_peer[0] && m_rd != 0) begin ld = 1; ld_len = 9; ld_kind = ctrl_wdata[3] ? 5 : 6; end
              else if (!m_peer[0] && m_wr != 0) begin ld = 1; ld_len = 9; ld_kind = 4; end
            end else begin
              m_adone = 1; m_peer = m_data; ld = 1; ld_len = 9;
              ld_kind = m_data[0] ? 3 : 2;
              if (m_data[0]) n_rd = 1;
            end
            n_wr = 0;
          end
          m_en = 1; m_sta = ctrl_wdata[1]; m_sto = ctrl_wdata[2]; m_ak = ctrl_wdata[3];
        end
      end
      if (cancel) p_act = 0;
      else if (ld != 0) begin p_act = 1; p_cnt = ld_len; p_kind = ld_kind; end
      else if (fire) p_act = 0;
      else if (p_act != 0 && tick) p_cnt = p_cnt - 1;
      m_ack = n_ack; m_data = n_data; m_wr = n_wr; m_rd = n_rd; m_code = n_code; m_irq = n_irq;
      if (mq_kind.size() > 0 && mq_kind[$] == -1) void'(mq_kind.pop_back());
    end
  end

  // per-clock comparison against the model, plus message capture
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_req, "status", status_o, (m_code & 8'hF8) | m_pre);
      chk(cur_req, "irq", irq_o, m_irq);
      chk(cur_req, "data", data_o, m_data);
      if (irq_o && !prev_irq) rises++;
      prev_irq = irq_o;
      if (msg_vld_o) begin
        mq_kind.push_back(msg_kind_o); mq_addr.push_back(msg_addr_o);
        mq_data.push_back(msg_data_o); mq_ack.push_back(msg_ack_o);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr_ctrl(input logic [4:0] v);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v; @(negedge clk); ctrl_wr = 0;
  endtask
  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_wr = 1; data_wdata = v; @(negedge clk); data_wr = 0;
  endtask
  task automatic rd_data();
    @(negedge clk); data_rd = 1; @(negedge clk); data_rd = 0;
  endtask
  task automatic wr_stat(input logic [1:0] v);
    @(negedge clk); stat_wr = 1; stat_wdata = v; @(negedge clk); stat_wr = 0;
  endtask
  task automatic give_ack(input logic a);
    @(negedge clk); rsp_ack_vld = 1; rsp_ack = a; @(negedge clk); rsp_ack_vld = 0;
  endtask
  task automatic give_data(input logic [7:0] d);
    @(negedge clk); rsp_data_vld = 1; rsp_data = d; @(negedge clk); rsp_data_vld = 0;
  endtask
  task automatic wait_irq(input string req);
    for (int i = 0; i < 120; i++) begin
      if (irq_o) return;
      @(negedge clk);
    end
    chk(req, "interrupt arrival", 0, 1);
  endtask
  task automatic expect_msg(input string req, input int kind, input int addr,
                            input int data, input int ack);
    idle(1);
    if (mq_kind.size() == 0) begin
      chk(req, "message present", 0, 1);
    end else begin
      chk(req, "msg kind", mq_kind.pop_front(), kind);
      chk(req, "msg addr", mq_addr.pop_front(), addr);
      if (data >= 0) chk(req, "msg data", mq_data[0], data);
      if (ack >= 0) chk(req, "msg ack", mq_ack[0], ack);
      void'(mq_data.pop_front()); void'(mq_ack.pop_front());
    end
  endtask
  task automatic expect_none(input string req);
    chk(req, "no message", mq_kind.size(), 0);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int r0;
    idle(3); rst_n = 1; idle(1);
    // R1 reset values
    chk("R1", "status", status_o, 8'hF8); chk("R1", "data", data_o, 8'hFF);
    chk("R1", "ctrl", ctrl_o, 0); chk("R1", "msg", msg_vld_o, 0);
    // R10 writes with enable low are ignored
    cur_req = "R10"; wr_ctrl(ST | SP | AK); give_ack(1); idle(40);
    chk("R10", "ctrl", ctrl_o, 0); chk("R10", "irq", irq_o, 0); expect_none("R10");
    // R2 start
    cur_req = "R2"; wr_ctrl(EN | ST); wait_irq("R2"); idle(1);
    chk("R2", "start code", status_o, 8'h08);
    // R6 no byte step without clearing the flag
    cur_req = "R6"; wr_data(8'hA4); wr_ctrl(EN); idle(4);
    expect_none("R6"); chk("R6", "irq kept", irq_o, 1);
    // R3 write address with ACK; R12 clear
    cur_req = "R3"; wr_ctrl(EN | IQ); chk("R12", "irq cleared", irq_o, 0);
    expect_msg("R3", 1, 8'hA4, -1, -1); give_ack(1); wait_irq("R3"); idle(1);
    chk("R3", "addr ack code", status_o, 8'h18);
    // R4 write data ACK, then NACK by silence
    cur_req = "R4"; wr_data(8'h3C); wr_ctrl(EN | IQ);
    expect_msg("R4", 3, 8'hA4, 8'h3C, -1); give_ack(1); wait_irq("R4"); idle(1);
    chk("R4", "data ack code", status_o, 8'h28);
    wr_data(8'h55); wr_ctrl(EN | IQ); expect_msg("R4", 3, 8'hA4, 8'h55, -1);
    wait_irq("R4"); idle(1); chk("R4", "data nack code", status_o, 8'h30);
    wr_ctrl(EN | IQ); idle(60); expect_none("R4"); chk("R4", "gated irq", irq_o, 0);
    // R2 repeated start, R3 read address NACK
    cur_req = "R2"; wr_ctrl(EN | ST); wait_irq("R2"); idle(1);
    chk("R2", "rstart code", status_o, 8'h10);
    cur_req = "R3"; wr_data(8'hA5); wr_ctrl(EN | IQ); expect_msg("R3", 1, 8'hA5, -1, -1);
    wait_irq("R3"); idle(1); chk("R3", "addr nack code", status_o, 8'h48);
    // R5 read bytes
    cur_req = "R5"; wr_ctrl(EN | IQ | AK); expect_msg("R5", 4, 8'hA5, -1, 1);
    give_data(8'h9E); wait_irq("R5"); idle(1);
    chk("R5", "read ack code", status_o, 8'h50); chk("R5", "read data", data_o, 8'h9E);
    rd_data(); wr_ctrl(EN | IQ); expect_msg("R5", 4, 8'hA5, -1, 0);
    wait_irq("R5"); idle(1); chk("R5", "read nack code", status_o, 8'h58);
    // R7 stop while open
    cur_req = "R7"; wr_ctrl(EN | SP | IQ); expect_msg("R7", 2, 8'hA5, -1, -1);
    wr_ctrl(EN);
    // R11 a second start replaces the pending one
    cur_req = "R11"; r0 = rises;
    wr_ctrl(EN | ST); wr_ctrl(EN); wr_ctrl(EN | ST); wait_irq("R11"); idle(50);
    chk("R11", "posted code", status_o, 8'h10); chk("R11", "irq rises", rises - r0, 1);
    // R7 stop when idle emits nothing, next start is a fresh one
    cur_req = "R7"; wr_ctrl(EN | SP | IQ); expect_msg("R7", 2, 0, -1, -1);
    wr_ctrl(EN); wr_ctrl(EN | SP); idle(4); expect_none("R7");
    wr_ctrl(EN); wr_ctrl(EN | ST); wait_irq("R7"); idle(1);
    chk("R7", "fresh start code", status_o, 8'h08);
    // R9 status write only touches the prescaler
    cur_req = "R9"; wr_stat(2'b11); idle(2); chk("R9", "status", status_o, 8'h0B);
    // R8 disable
    cur_req = "R8"; wr_ctrl(EN | AK); wr_ctrl(5'h00); idle(2);
    chk("R8", "status", status_o, 8'hFB); chk("R8", "irq", irq_o, 0);
    chk("R8", "data", data_o, 8'hFF); chk("R8", "ctrl", ctrl_o, 0);
    // R10 responder ignored while disabled
    cur_req = "R10"; give_data(8'h12); idle(2); chk("R10", "data", data_o, 8'hFF);
    idle(2);
    finish_run();
  end
endmodule